// File: doc/BRIEF.md
# Timer Prescaler with Self-Clearing Reset Request

This block divides a prescaler clock by a power of two and hands a timer a single-cycle count-enable pulse. A 10-bit counter runs freely on the prescaler clock. A 3-bit select code chooses how many of its low-order bits must all be ones before a pulse is issued. Code zero stops the pulse stream.

Software can restart the division by writing one to a reset bit. The block clears that bit by itself. The read-back of the bit depends on the clocking mode:

- **Synchronous mode:** the prescaler clock is the system clock. The write clears the counter at the next edge and the bit always reads zero.
- **Asynchronous mode:** the prescaler clock is an unrelated slow clock. The request crosses into the slow domain through a synchronizer, and completion crosses back through a second one. The bit reads one from the cycle after the write until the handshake has finished, so software can poll it to learn that the restart has taken effect.

Top module: `tmr_prescaler`

## Requirements
- R1: After reset the counter is zero and the tick is low. The counter then advances by one on every prescaler edge and wraps from 1023 to 0. The tick is registered: it is high for exactly the one prescaler cycle that follows an edge at which the low-order bits of the count, as chosen by the select code, were all ones.
- R2: The select code maps as follows: 0 stopped (tick never high), 1 divide by 1, 2 divide by 8, 3 divide by 32, 4 divide by 64, 5 divide by 128, 6 divide by 256, 7 divide by 1024. The code is applied at the prescaler edge at which it is sampled.
- R3: In synchronous mode (`async_mode`=0, prescaler clock equal to the system clock), a write strobe with data one clears the counter and the tick at the next edge.
- R4: In synchronous mode `rst_bit` always reads zero.
- R5: In asynchronous mode, a write of one while `rst_bit` reads zero makes `rst_bit` read one from the next system cycle onward.
- R6: In asynchronous mode the counter and the tick are cleared at the third prescaler edge after the system edge that accepted the write. `rst_bit` stays one at least until that clear.
- R7: After the asynchronous clear, `rst_bit` returns to zero within 60 system cycles once the completion handshake has come back.
- R8: A write strobe with data zero has no effect, in either mode, on the counter, the tick or `rst_bit`.
- R9: In asynchronous mode, a write of one while `rst_bit` already reads one starts no second clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock; the write side and the read-back run on it |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| pre_clk | input | 1 | Prescaler clock; equals `sys_clk` in synchronous mode |
| pre_rst | input | 1 | Synchronous active-high reset, prescaler domain |
| async_mode | input | 1 | 1 = prescaler runs from an unrelated clock |
| clk_sel | input | 3 | Division select code (see R2) |
| rst_wr_en | input | 1 | Write strobe for the reset bit, system domain |
| rst_wr_data | input | 1 | Data written to the reset bit |
| tick | output | 1 | Single-cycle count enable, prescaler domain |
| rst_bit | output | 1 | Read-back value of the reset bit |

## Verification
The results fall due at these points:

- **Tick:** follows the count one prescaler edge later. The bench's model therefore computes the expected tick at each prescaler rising edge and compares it at the following falling edge.
- **Synchronous clear:** lands at the first edge after the strobe.
- **Asynchronous clear:** lands at the third prescaler edge after the accepting system edge. The model counts prescaler edges from its own record of the accepted write and clears its counter exactly there.
- **Read-back bit:** is due one system cycle after the write. It is compared at the falling system edge.

The drop of the read-back bit is allowed a window, because it depends on the phase between the clocks. The bench checks both that the bit stays set while the clear is still outstanding and that it drops within the bound.

// File: rtl/tmr_prescaler_pkg.sv
package tmr_prescaler_pkg;

  localparam int unsigned SEL_W = 3;

  // number of low-order count bits that must be all ones for a tick
  function automatic int unsigned tap_len(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd1:    tap_len = 0;
      3'd2:    tap_len = 3;
      3'd3:    tap_len = 5;
      3'd4:    tap_len = 6;
      3'd5:    tap_len = 7;
      3'd6:    tap_len = 8;
      3'd7:    tap_len = 10;
      default: tap_len = 0;
    endcase
  endfunction

endpackage

// File: rtl/tmr_psc_sync.sv
module tmr_psc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/tmr_psc_req.sv
module tmr_psc_req (
  input  logic clk,
  input  logic rst,
  input  logic async_mode,
  input  logic wr_en,
  input  logic wr_data,
  input  logic ack_in,
  output logic req,
  output logic busy
);
  // four-phase request: raised by a write, dropped when the ack returns
  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0;
    end else if (req && ack_in) begin
      req <= 1'b0;
    end else if (async_mode && wr_en && wr_data && !req && !ack_in) begin
      req <= 1'b1;
    end
  end

  assign busy = req | ack_in;
endmodule

// File: rtl/tmr_psc_core.sv
module tmr_psc_core
  import tmr_prescaler_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;
  logic             hit;

  always_comb begin
    mask = '0;
    for (int i = 0; i < CNT_W; i++) begin
      mask[i] = (i < int'(tap_len(sel)));
    end
  end

  assign hit = (sel != '0) && ((cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= hit;
    end
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_prescaler_pkg::*;
#(
  parameter int unsigned CNT_W       = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             sys_clk,
  input  logic             sys_rst,
  input  logic             pre_clk,
  input  logic             pre_rst,
  input  logic             async_mode,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             rst_wr_en,
  input  logic             rst_wr_data,
  output logic             tick,
  output logic             rst_bit
);
  logic req;
  logic busy;
  logic req_pre;
  logic ack_pre;
  logic ack_sys;
  logic clr_async;
  logic clr_sync;
  logic clr;

  tmr_psc_req u_req (
    .clk        (sys_clk),
    .rst        (sys_rst),
    .async_mode (async_mode),
    .wr_en      (rst_wr_en),
    .wr_data    (rst_wr_data),
    .ack_in     (ack_sys),
    .req        (req),
    .busy       (busy)
  );

  tmr_psc_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk (pre_clk),
    .rst (pre_rst),
    .d   (req),
    .q   (req_pre)
  );

  // ack follows the synchronized request one edge later: set at the clear edge
  always_ff @(posedge pre_clk) begin
    if (pre_rst) ack_pre <= 1'b0;
    else         ack_pre <= req_pre;
  end

  tmr_psc_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk (sys_clk),
    .rst (sys_rst),
    .d   (ack_pre),
    .q   (ack_sys)
  );

  assign clr_async = req_pre & ~ack_pre;
  assign clr_sync  = ~async_mode & rst_wr_en & rst_wr_data;
  assign clr       = async_mode ? clr_async : clr_sync;

  tmr_psc_core #(.CNT_W(CNT_W)) u_core (
    .clk  (pre_clk),
    .rst  (pre_rst),
    .clr  (clr),
    .sel  (clk_sel),
    .tick (tick)
  );

  assign rst_bit = async_mode & busy;
endmodule

// File: rtl/tmr_prescaler_chk.sv
module tmr_prescaler_chk (
  input logic       sys_clk,
  input logic       sys_rst,
  input logic       pre_clk,
  input logic       pre_rst,
  input logic       async_mode,
  input logic [2:0] clk_sel,
  input logic       rst_wr_en,
  input logic       rst_wr_data,
  input logic       tick,
  input logic       rst_bit
);
  a_r4_sync_reads_zero: assert property (@(posedge sys_clk) disable iff (sys_rst)
    !async_mode |-> !rst_bit);

  a_r5_write_sets_bit: assert property (@(posedge sys_clk) disable iff (sys_rst)
    (async_mode && !rst_bit && rst_wr_en && rst_wr_data) |=> rst_bit);

  a_r8_zero_write_idle: assert property (@(posedge sys_clk) disable iff (sys_rst)
    (!rst_bit && rst_wr_en && !rst_wr_data) |=> !rst_bit);

  a_r2_stopped_no_tick: assert property (@(posedge pre_clk) disable iff (pre_rst)
    (clk_sel == 3'd0) |=> !tick);

  a_r1_tick_single: assert property (@(posedge pre_clk) disable iff (pre_rst)
    (tick && clk_sel > 3'd1 && $stable(clk_sel)) |=> !tick);
endmodule

bind tmr_prescaler tmr_prescaler_chk u_chk (
  .sys_clk     (sys_clk),
  .sys_rst     (sys_rst),
  .pre_clk     (pre_clk),
  .pre_rst     (pre_rst),
  .async_mode  (async_mode),
  .clk_sel     (clk_sel),
  .rst_wr_en   (rst_wr_en),
  .rst_wr_data (rst_wr_data),
  .tick        (tick),
  .rst_bit     (rst_bit)
);

// File: tb/tmr_prescaler_test.sv
module tmr_prescaler_test;
  logic       clk = 1'b0;
  logic       slow_clk = 1'b0;
  logic       slow_mode = 1'b0;
  logic       rst = 1'b1;
  logic       async_mode = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       wr = 1'b0;
  logic       wdata = 1'b0;
  logic       pre_clk;
  logic       tick;
  logic       rst_bit;

  int checks = 0;
  int errors = 0;
  int m_cnt = 0;
  bit m_tick = 1'b0;
  int pend = 0;
  int req_count = 0;
  int taken = 0;
  int done_count = 0;
  int seen_done = 0;
  bit started = 1'b0;
  bit bit_prev = 1'b0;
  bit waiting_drop = 1'b0;
  int since_clr = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  always #15 slow_clk = ~slow_clk;
  assign pre_clk = slow_mode ? slow_clk : clk;

  tmr_prescaler uut (
    .sys_clk     (clk),
    .sys_rst     (rst),
    .pre_clk     (pre_clk),
    .pre_rst     (rst),
    .async_mode  (async_mode),
    .clk_sel     (sel),
    .rst_wr_en   (wr),
    .rst_wr_data (wdata),
    .tick        (tick),
    .rst_bit     (rst_bit)
  );

  function automatic int div_of(input logic [2:0] s);
    case (s)
      3'd1: div_of = 1;
      3'd2: div_of = 8;
      3'd3: div_of = 32;
      3'd4: div_of = 64;
      3'd5: div_of = 128;
      3'd6: div_of = 256;
      3'd7: div_of = 1024;
      default: div_of = 0;
    endcase
  endfunction

  // accepted asynchronous writes, judged from the bit read before the edge
  always @(posedge clk) begin
    if (!rst && async_mode && wr && wdata && !bit_prev) req_count++;
  end

  // behavioural reference of the prescaler (R1, R2, R3, R6, R9)
  always @(posedge pre_clk) begin
    bit clr;
    int d;
    if (rst) begin
      m_cnt = 0; m_tick = 1'b0; pend = 0; started = 1'b1;
      taken = req_count; done_count = 0; seen_done = 0;
    end else begin
      clr = 1'b0;
      if (!async_mode && wr && wdata) clr = 1'b1;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin clr = 1'b1; done_count++; end
      end else if (req_count != taken) begin
        taken = req_count;
        pend = 2;
      end
      if (clr) begin
        m_cnt = 0; m_tick = 1'b0;
      end else begin
        d = div_of(sel);
        m_tick = (d != 0) && ((m_cnt % d) == d - 1);
        m_cnt = (m_cnt + 1) % 1024;
      end
    end
  end

  always @(negedge pre_clk) begin
    if (started && !finished) begin
      checks++;
      if (tick !== m_tick) begin
        errors++;
        $display("FAIL R1/R2/R3/R6 tick act=%b exp=%b sel=%0d", tick, m_tick, sel);
      end
    end
  end

  // read-back bit (R4, R5, R6, R7, R8)
  always @(negedge clk) begin
    if (started && !rst && !finished) begin
      if (done_count != seen_done) begin
        seen_done = done_count; waiting_drop = 1'b1; since_clr = 0;
      end
      checks++;
      if (!async_mode) begin
        if (rst_bit !== 1'b0) begin
          errors++; $display("FAIL R4 rst_bit act=%b exp=0", rst_bit);
        end
      end else if (req_count != done_count) begin
        if (rst_bit !== 1'b1) begin
          errors++; $display("FAIL R5/R6 rst_bit act=%b exp=1", rst_bit);
        end
      end else if (waiting_drop) begin
        if (rst_bit === 1'b0) begin
          waiting_drop = 1'b0;
        end else begin
          since_clr++;
          if (since_clr > 60) begin
            errors++; waiting_drop = 1'b0;
            $display("FAIL R7 rst_bit act=%b exp=0 after clear", rst_bit);
          end
        end
      end else if (rst_bit !== 1'b0) begin
        errors++; $display("FAIL R8 rst_bit act=%b exp=0 when idle", rst_bit);
      end
    end
    bit_prev = rst_bit;
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_bit(input logic d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (tick !== 1'b0 || rst_bit !== 1'b0) begin
      errors++; $display("FAIL R1 reset tick=%b bit=%b exp=0/0", tick, rst_bit);
    end
    // synchronous mode: every select code
    sel = 3'd1; run(20);
    sel = 3'd2; run(40);
    sel = 3'd3; run(100);
    sel = 3'd4; run(140);
    sel = 3'd5; run(270);
    sel = 3'd6; run(520);
    sel = 3'd7; run(2100);
    sel = 3'd0; run(50);
    // R3 clear mid-count, R8 zero write
    sel = 3'd2; run(13);
    write_bit(1'b1); run(20);
    write_bit(1'b0); run(20);
    write_bit(1'b1); run(3);
    write_bit(1'b1); run(30);
    // switch to asynchronous clock under reset
    @(negedge clk); rst = 1'b1;
    run(2);
    slow_mode = 1'b1; async_mode = 1'b1;
    repeat (3) @(negedge slow_clk);
    @(negedge clk); rst = 1'b0;
    sel = 3'd2; run(100);
    // R5/R6/R7 restart
    write_bit(1'b1); run(120);
    // R8 zero write
    write_bit(1'b0); run(60);
    // R9 write while busy
    write_bit(1'b1); run(4);
    write_bit(1'b1); run(2);
    write_bit(1'b1); run(120);
    sel = 3'd3; run(300);
    write_bit(1'b1); run(150);
    sel = 3'd1; run(60);
    write_bit(1'b1); run(150);
    sel = 3'd0; run(60);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    finished = 1'b1;
    checks++; errors++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule